// File: doc/BRIEF.md
# Pin Edge Event Counter

The block counts transitions on a single dedicated input pin in an eight-bit register. Counting only happens when the accumulator is switched on and left in event mode. A selectable gated-time mode stops counting and does nothing else. A control bit chooses whether rising or falling transitions are counted. The pin also has a direction bit. While the pin is marked as an output, the block holds its sampled level and ignores whatever arrives on `pin_i`.

When an increment carries the count from its maximum back to zero, a sticky overflow flag is set. That flag, ANDed with an interrupt enable bit, drives `irq_o`. Software sees four byte-wide locations through a simple write strobe and a combinational read port: control, count, status and pin level. It can preload or read the count at any time and clears the flag by writing a one to it.

Top module: `pacnt_top`

## Requirements
- R1: After reset the count, the control bits, the overflow flag and `irq_o` are all zero.
- R2: The count increments only when control bit 0 (enable) is 1 and control bit 1 (gated mode) is 0. In every other setting, pin transitions leave the count unchanged.
- R3: With control bit 2 set to 1, a 0-to-1 change of the pin level increments the count. With it at 0, a 1-to-0 change increments the count. A change the other way does not increment.
- R4: An increment from 255 lands on 0 and sets the overflow flag (bit 0 at address 2). Other increments and direct writes of the count, including a write of 0, do not set it.
- R5: The overflow flag stays set until a write to address 2 with bit 0 equal to 1. Writing 0 there has no effect. If a wrap and a clearing write occur in the same cycle, the flag ends up set.
- R6: `irq_o` is 1 exactly when the overflow flag is set and control bit 3 (interrupt enable) is 1.
- R7: While control bit 4 (direction) is 1, changes on `pin_i` are ignored. The pin level read at address 3 bit 0 holds and the count does not change.
- R8: A write to the count at address 1 in the same cycle as a counted edge stores the written value, and that edge is dropped.
- R9: The register map is: address 0 control bits [4:0], address 1 count, address 2 status, address 3 pin level (read only). Unused bits read as zero. A counted edge becomes visible one clock after `pin_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External level of the counted pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A pin change applied before a rising clock edge shows up in the count, the flag, the pin level and `irq_o` right after that edge, because each of these passes through exactly one register. Register writes follow the same one-edge path. Read data depends only on the address and the current state. The bench therefore changes every input on the falling edge and reads results on the next falling edge, which is one register stage later and half a period from any active edge. Same-cycle collisions, such as a write with an edge or a clear with a wrap, are produced by setting both inputs on the same falling edge.

// File: rtl/pacnt_pkg.sv
package pacnt_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_PIN   = 2'd3
  } reg_sel_e;

  // bit 0 enable, 1 gated mode, 2 rising edge, 3 irq enable, 4 pin is output
  typedef struct packed {
    logic dir_out;
    logic irq_en;
    logic rise;
    logic gated;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/pacnt_pin.sv
module pacnt_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic dir_out_i,
  input  logic count_en_i,
  input  logic rise_i,
  output logic level_o,
  output logic inc_o
);
  logic level_q;
  logic change;

  assign change  = ~dir_out_i & (pin_i ^ level_q);
  assign inc_o   = change & count_en_i & (rise_i ? pin_i : ~pin_i);
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        level_q <= 1'b0;
    else if (change)    level_q <= pin_i;
  end

  assert_dir_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_out_i |=> (level_o == $past(level_o)));
endmodule

// File: rtl/pacnt_counter.sv
module pacnt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  // write beats a same-cycle increment
  assign wrap_o = inc_i & ~wr_i & (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i)));
  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pacnt_ctrl.sv
module pacnt_ctrl
  import pacnt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic              ovf_o
);
  ctrl_t ctrl_q;
  logic  ovf_q;
  logic  clr;
  logic  unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];
  assign clr = we_i & (sel_i == SEL_STAT) & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_q <= '0;
    else if (we_i && sel_i == SEL_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // a wrap beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (wrap_i)  ovf_q <= 1'b1;
    else if (clr)     ovf_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_q;

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr) |=> ovf_q);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q);
endmodule

// File: rtl/pacnt_top.sv
module pacnt_top
  import pacnt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = DATA_W;

  reg_sel_e         sel;
  ctrl_t            ctrl;
  logic             ovf;
  logic             level;
  logic             inc;
  logic             wrap;
  logic             count_en;
  logic [CNT_W-1:0] cnt;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign count_en = ctrl.enable & ~ctrl.gated;

  pacnt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .wrap_i  (wrap),
    .ctrl_o  (ctrl),
    .ovf_o   (ovf)
  );

  pacnt_pin u_pin (
    .clk_i, .rst_ni,
    .pin_i,
    .dir_out_i  (ctrl.dir_out),
    .count_en_i (count_en),
    .rise_i     (ctrl.rise),
    .level_o    (level),
    .inc_o      (inc)
  );

  pacnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i   (inc),
    .wr_i    (reg_we_i && sel == SEL_COUNT),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_CTRL:  reg_rdata_o[CTRL_W-1:0] = ctrl;
      SEL_COUNT: reg_rdata_o = cnt;
      SEL_STAT:  reg_rdata_o[0] = ovf;
      SEL_PIN:   reg_rdata_o[0] = level;
    endcase
  end

  assign irq_o = ovf & ctrl.irq_en;

  assert_flag_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> $past(wrap));
  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en |-> !inc);
  assert_irq_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf);
endmodule

// File: tb/sim_pacnt_top.sv
module sim_pacnt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_cnt = '0;
  logic       exp_pin = 1'b0;
  logic       exp_flag = 1'b0;

  always #10 clk = ~clk;

  pacnt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // apply a pin level and update the model; cfg bits: en, gated, rise, ie, dir
  task automatic drive_pin(input logic v, input logic [4:0] cfg);
    @(negedge clk);
    pin = v;
    @(negedge clk);
    if (!cfg[4] && v != exp_pin) begin
      exp_pin = v;
      if (cfg[0] && !cfg[1] && (cfg[2] == v)) begin
        if (exp_cnt == 8'hff) exp_flag = 1'b1;
        exp_cnt = exp_cnt + 8'd1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] cfg;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 count");
    rd(2'd2, 8'h00, "R1 flag");
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    // R2 R3 R7 sweep over enable, gated, polarity, direction
    for (int c = 0; c < 32; c++) begin
      if (c[3]) continue;
      cfg = 5'(c);
      pin = exp_pin;
      wr(2'd0, {3'd0, cfg});
      rd(2'd0, {3'd0, cfg}, "R9 ctrl readback");
      for (int t = 0; t < 4; t++) begin
        drive_pin(t[0] ? 1'b0 : 1'b1, cfg);
        rd(2'd1, exp_cnt, cfg[4] ? "R7 count" : (cfg[1] ? "R2 count" : "R3 count"));
        rd(2'd3, {7'd0, exp_pin}, "R7 pin level");
      end
    end
    rd(2'd2, 8'h00, "R4 no flag without wrap");

    // R4 wrap and flag, R6 irq
    cfg = 5'b00101;
    pin = exp_pin;
    wr(2'd0, {3'd0, cfg});
    wr(2'd1, 8'h00);
    exp_cnt = 8'h00;
    rd(2'd2, 8'h00, "R4 write zero no flag");
    wr(2'd1, 8'hfe);
    exp_cnt = 8'hfe;
    if (exp_pin) drive_pin(1'b0, cfg);
    drive_pin(1'b1, cfg);
    rd(2'd1, 8'hff, "R4 count 255");
    rd(2'd2, 8'h00, "R4 no flag at 255");
    drive_pin(1'b0, cfg);
    drive_pin(1'b1, cfg);
    rd(2'd1, 8'h00, "R4 wrap to 0");
    rd(2'd2, 8'h01, "R4 flag set");
    check("R6 irq masked", {7'd0, irq}, 8'h00);
    cfg = 5'b01101;
    wr(2'd0, {3'd0, cfg});
    check("R6 irq raised", {7'd0, irq}, 8'h01);
    // R5 sticky, write 0 ignored, write 1 clears
    drive_pin(1'b0, cfg);
    drive_pin(1'b1, cfg);
    rd(2'd2, 8'h01, "R5 sticky after count");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h01, "R5 write 0 no effect");
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h00, "R5 clear");
    check("R6 irq dropped", {7'd0, irq}, 8'h00);

    // R8 write beats a same-cycle counted edge
    drive_pin(1'b0, cfg);
    @(negedge clk);
    pin = 1'b1; we = 1'b1; addr = 2'd1; wdata = 8'h10;
    @(negedge clk);
    we = 1'b0;
    exp_pin = 1'b1; exp_cnt = 8'h10;
    rd(2'd1, 8'h10, "R8 write wins");
    rd(2'd3, 8'h01, "R8 pin level");
    drive_pin(1'b0, cfg);
    drive_pin(1'b1, cfg);
    rd(2'd1, exp_cnt, "R8 counting resumes");

    // R5 wrap beats same-cycle clear
    wr(2'd1, 8'hff);
    drive_pin(1'b0, cfg);
    @(negedge clk);
    pin = 1'b1; we = 1'b1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk);
    we = 1'b0;
    rd(2'd1, 8'h00, "R5 wrap count");
    rd(2'd2, 8'h01, "R5 set wins over clear");
    check("R6 irq on collision", {7'd0, irq}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule